// File: doc/BRIEF.md
# Far-Space Select Sequencer

This block helps a processor reach a second address space for single operands. Two privileged instructions, one for the source operand and one for the destination operand, arm a one-shot override. When the matching operand bus cycle comes, the block flips the address-space select line for that cycle only. After that cycle the override is spent. Workspace register traffic and other cycles keep the select line as driven.

A 3-bit sequence state records which overrides are armed and whether the latest instruction opened a new chain. Supervisor code can read this state in the top three bits of a 16-bit word. It uses that word to find the start of a chain when it needs to restart one. After either instruction, interrupt recognition is held off until the next instruction starts, so the armed override reaches the instruction it was meant for. In user mode the instructions arm nothing and raise a privileged-operation error pulse instead.

Top module: `far_space_seq`

## Requirements
- R1: After reset the sequence word reads 0x0000, the error and defer outputs are low, and `psel_out` equals `psel_in`.
- R2: Only the instruction words 0x0780 (source form) and 0x07C0 (destination form) are recognised. Any other word leaves the sequence word at its value and drops the defer output.
- R3: The instruction word is sampled on the edge where `instr_valid` is high. The sequence state changes on the following edge, which is the second cycle of the instruction.
- R4: Bit 15 of the sequence word marks an armed source override. Bit 13 marks an armed destination override. Bit 14 marks the first instruction of a chain and is set only when neither override was armed before. A first source instruction therefore reads 0xC000, and a first destination instruction reads 0x6000. A destination instruction after a pending source override reads 0xA000.
- R5: With a source override armed, the next bus cycle with `bus_cycle` = 01 has `psel_out` = !`psel_in`, and the override is then cleared. The same holds for the destination override and `bus_cycle` = 10. A later cycle of the same type is not inverted.
- R6: Workspace cycles (`bus_cycle` = 00) and other cycles (11) never invert the select line, and they leave any armed override pending.
- R7: When status bit 8 is 1 (user mode) as either instruction is sampled, `priv_err` pulses high for one cycle in the second cycle. The sequence state is left unchanged and the defer output is not raised.
- R8: A privileged instruction raises `irq_defer` in its second cycle. The output stays high until the next instruction is sampled.
- R9: `irq_entry` clears all armed overrides, the chain marker and `irq_defer` on the next edge.
- R10: Using an override also clears the chain marker, so a chain that has run out of overrides reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction word is presented for decode |
| instr_word | input | 16 | First instruction word |
| status_word | input | 16 | Processor status; bit 8 = 1 means user mode |
| irq_entry | input | 1 | Interrupt entry; clears pending overrides |
| bus_active | input | 1 | A bus cycle is in progress |
| bus_cycle | input | 2 | Cycle type: 00 workspace, 01 source, 10 destination, 11 other |
| psel_in | input | 1 | Address-space select from the processor |
| psel_out | output | 1 | Address-space select to memory |
| priv_err | output | 1 | Privileged-operation error pulse |
| irq_defer | output | 1 | Hold off interrupt recognition |
| seq_word | output | 16 | Sequence state in bits 15..13, zero below |

## Verification
The checker assumes that `bus_cycle` is only meaningful while `bus_active` is high. It also assumes that a source-cycle inversion is never in the same cycle as a new instruction's second cycle, since the new instruction would arm the override again. The stimulus keeps to this: instructions and bus cycles are issued in separate, non-overlapping tasks, and instructions are spaced at least two cycles apart. The sweeps cover every instruction word from 0x0000 to 0x0FFF and every bus-cycle type with both select values against the armed state.

// File: rtl/far_space_seq.sv
module far_space_seq #(
  parameter int          W        = 16,
  parameter logic [15:0] SRC_OP   = 16'h0780,
  parameter logic [15:0] DST_OP   = 16'h07C0,
  parameter int          PRIV_BIT = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         instr_valid,
  input  logic [W-1:0] instr_word,
  input  logic [W-1:0] status_word,
  input  logic         irq_entry,
  input  logic         bus_active,
  input  logic [1:0]   bus_cycle,
  input  logic         psel_in,
  output logic         psel_out,
  output logic         priv_err,
  output logic         irq_defer,
  output logic [W-1:0] seq_word
);
  localparam int PAD = W - 3;

  logic       hit_src_q, hit_dst_q, user_q;
  logic [2:0] st, nxt;
  logic       use_src, use_dst, upd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_src_q <= 1'b0;
      hit_dst_q <= 1'b0;
      user_q    <= 1'b0;
    end else begin
      hit_src_q <= instr_valid && (instr_word == SRC_OP);
      hit_dst_q <= instr_valid && (instr_word == DST_OP);
      user_q    <= status_word[PRIV_BIT];
    end
  end

  assign upd     = (hit_src_q || hit_dst_q) && !user_q;
  assign use_src = bus_active && (bus_cycle == 2'b01) && st[2];
  assign use_dst = bus_active && (bus_cycle == 2'b10) && st[0];
  assign psel_out = psel_in ^ (use_src || use_dst);
  assign seq_word = {st, {PAD{1'b0}}};

  always_comb begin
    nxt = st;
    if (use_src) nxt[2] = 1'b0;
    if (use_dst) nxt[0] = 1'b0;
    if (use_src || use_dst) nxt[1] = 1'b0;
    if (upd) begin
      nxt[1] = !st[2] && !st[0];
      if (hit_src_q) nxt[2] = 1'b1;
      if (hit_dst_q) nxt[0] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= 3'b000;
      priv_err  <= 1'b0;
      irq_defer <= 1'b0;
    end else begin
      priv_err <= (hit_src_q || hit_dst_q) && user_q;
      if (irq_entry) begin
        st        <= 3'b000;
        irq_defer <= 1'b0;
      end else begin
        st <= nxt;
        if (upd) irq_defer <= 1'b1;
        else if (instr_valid) irq_defer <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/far_space_seq_chk.sv
module far_space_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_entry,
  input logic        bus_active,
  input logic [1:0]  bus_cycle,
  input logic        psel_in,
  input logic        psel_out,
  input logic        priv_err,
  input logic        irq_defer,
  input logic [15:0] seq_word,
  input logic        upd
);
  AST_WS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cycle == 2'b00) |-> (psel_out == psel_in)); // R6
  AST_OTHER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cycle == 2'b11) |-> (psel_out == psel_in)); // R6
  AST_SRC_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && bus_cycle == 2'b01 && psel_out != psel_in && !upd && !irq_entry) |=> !seq_word[15]); // R5
  AST_ERR_NO_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    priv_err |-> !$rose(irq_defer)); // R7
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_entry |=> (seq_word == 16'h0000) && !irq_defer); // R9
endmodule

bind far_space_seq far_space_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .irq_entry(irq_entry), .bus_active(bus_active),
  .bus_cycle(bus_cycle), .psel_in(psel_in), .psel_out(psel_out),
  .priv_err(priv_err), .irq_defer(irq_defer), .seq_word(seq_word), .upd(upd)
);

// File: tb/test_far_space_seq.sv
module test_far_space_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_valid = 1'b0, irq_entry = 1'b0, bus_active = 1'b0, psel_in = 1'b0;
  logic [15:0] instr_word = '0, status_word = '0;
  logic [1:0] bus_cycle = 2'b11;
  logic psel_out, priv_err, irq_defer;
  logic [15:0] seq_word;

  int checks = 0, errors = 0;
  logic [2:0] es = 3'b000;
  logic ed = 1'b0;

  always #2.5 clk = ~clk;

  far_space_seq i_far_space_seq (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .status_word(status_word), .irq_entry(irq_entry), .bus_active(bus_active),
    .bus_cycle(bus_cycle), .psel_in(psel_in), .psel_out(psel_out),
    .priv_err(priv_err), .irq_defer(irq_defer), .seq_word(seq_word)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w, input logic usr, input logic quiet);
    logic is_op;
    is_op = (w == 16'h0780) || (w == 16'h07C0);
    @(negedge clk);
    instr_valid = 1'b1; instr_word = w; status_word = usr ? 16'h0100 : 16'h0000;
    @(negedge clk);
    instr_valid = 1'b0; status_word = 16'h0000;
    if (!quiet) chk(seq_word == {es, 13'b0}, "R3 state unchanged in first cycle", seq_word, {es, 13'b0});
    if (is_op && !usr) begin
      es[1] = !es[2] && !es[0];
      if (w == 16'h0780) es[2] = 1'b1; else es[0] = 1'b1;
      ed = 1'b1;
    end else ed = 1'b0;
    @(negedge clk);
    chk(seq_word == {es, 13'b0}, "R2/R4 sequence word", seq_word, {es, 13'b0});
    chk(irq_defer == ed, "R8 defer", irq_defer, ed);
    if (!quiet) chk(priv_err == (is_op && usr), "R7 privilege error", priv_err, is_op && usr);
  endtask

  task automatic bus(input logic [1:0] c, input logic p);
    logic inv;
    @(negedge clk);
    bus_active = 1'b1; bus_cycle = c; psel_in = p;
    inv = (c == 2'b01 && es[2]) || (c == 2'b10 && es[0]);
    #1;
    chk(psel_out == (p ^ inv), "R5/R6 select line", psel_out, p ^ inv);
    if (inv) begin
      if (c == 2'b01) es[2] = 1'b0; else es[0] = 1'b0;
      es[1] = 1'b0;
    end
    @(negedge clk);
    bus_active = 1'b0; bus_cycle = 2'b11;
    chk(seq_word == {es, 13'b0}, "R10 state after bus cycle", seq_word, {es, 13'b0});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    psel_in = 1'b1;
    #1;
    chk(seq_word == 16'h0 && !priv_err && !irq_defer, "R1 reset state", seq_word, 0);
    chk(psel_out == 1'b1, "R1 select passthrough", psel_out, 1);
    // R2 sweep of instruction words
    for (int w = 0; w < 4096; w++) begin
      if (w != 16'h0780 && w != 16'h07C0) issue(16'(w), 1'b0, 1'b1);
    end
    // R4 first source, then R5/R6 sweep of bus types
    issue(16'h0780, 1'b0, 1'b0);
    chk(seq_word == 16'hC000, "R4 first source", seq_word, 16'hC000);
    for (int pat = 0; pat < 4; pat++) begin
      if (pat[0]) issue(16'h0780, 1'b0, 1'b0);
      if (pat[1]) issue(16'h07C0, 1'b0, 1'b0);
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 2; p++) bus(2'(c), p[0]);
    end
    // R4 chain destination then source
    issue(16'h07C0, 1'b0, 1'b0);
    chk(seq_word == 16'h6000, "R4 first destination", seq_word, 16'h6000);
    issue(16'h0780, 1'b0, 1'b0);
    chk(seq_word == 16'hA000, "R4 chained", seq_word, 16'hA000);
    bus(2'b00, 1'b0);
    bus(2'b10, 1'b0);
    bus(2'b10, 1'b0);
    chk(seq_word == 16'h8000, "R5 destination spent", seq_word, 16'h8000);
    bus(2'b01, 1'b1);
    chk(seq_word == 16'h0000, "R10 chain ended", seq_word, 16'h0000);
    // R7 user mode
    issue(16'h0780, 1'b1, 1'b0);
    issue(16'h07C0, 1'b1, 1'b0);
    issue(16'h1234, 1'b1, 1'b0);
    // R8 defer released by next instruction
    issue(16'h07C0, 1'b0, 1'b0);
    chk(irq_defer == 1'b1, "R8 defer raised", irq_defer, 1);
    issue(16'h1234, 1'b0, 1'b0);
    chk(irq_defer == 1'b0, "R8 defer released", irq_defer, 0);
    // R9 interrupt entry
    issue(16'h07C0, 1'b0, 1'b0);
    @(negedge clk); irq_entry = 1'b1;
    @(negedge clk); irq_entry = 1'b0;
    es = 3'b000; ed = 1'b0;
    chk(seq_word == 16'h0 && !irq_defer, "R9 cleared by interrupt", seq_word, 0);
    bus(2'b10, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule